// File: doc/BRIEF.md
# Circular Capture Buffer With Trigger Position

This block records a stream of sampled data words into a circular store while it is armed, and freezes a window around a trigger event. A position select decides how much of the window shows history from before the trigger and how much shows what followed it. Once the window is complete the block raises a done flag, stops writing, and lets a host read the frozen samples back by index, where index 0 is always the oldest valid sample. A continuous mode ignores the trigger and keeps overwriting the store until a stop request freezes it.

Trigger detection happens upstream: the block only sees a trigger pulse. The store depth is a parameter and may be zero. At depth zero nothing is stored, and the block only reports, through the done flag, that a trigger arrived.

Top module: `cap_buffer`

## Requirements
- R1: After reset `busy`, `done`, `valid_cnt` and `trig_pos` are all 0.
- R2: With `mode_sel`=0 (mostly post), DEPTH/8 pre-trigger samples are kept and DEPTH−DEPTH/8 samples are taken from the trigger sample onward. The trigger sample counts as the first post-trigger sample.
- R3: With `mode_sel`=1 (center), DEPTH/2 pre-trigger and DEPTH−DEPTH/2 post-trigger samples are kept.
- R4: With `mode_sel`=2 (mostly pre), DEPTH−DEPTH/8 pre-trigger and DEPTH/8 post-trigger samples are kept.
- R5: If the trigger arrives before the pre-trigger share has filled, it is accepted anyway. `trig_pos` then equals the number of samples stored before it, and `valid_cnt` equals that number plus the post-trigger count.
- R6: With `mode_sel`=3 (continuous), the trigger is ignored and recording continues until `stop`. After `stop`, `valid_cnt` = min(samples stored, DEPTH) and `trig_pos` = `valid_cnt`.
- R7: A sample is stored only on a clock edge where `smp_en` is 1. A trigger is recognised only when `smp_en` is 1 in the same cycle.
- R8: While `done` is 1 and `arm` is 0, no sample is written: `valid_cnt` and the read data stay unchanged.
- R9: `rd_data` shows, one clock after `rd_idx` is applied, the sample at position `rd_idx` in time order, oldest first. The trigger sample sits at index `trig_pos`.
- R10: In a triggered mode, `stop` before the trigger ends the capture. `valid_cnt` and `trig_pos` then both equal the number of samples held (saturating at DEPTH).
- R11: `arm` has priority over every other input. It clears `done`, sets `busy`, and resets the count of held samples to 0 on the next edge.
- R12: With DEPTH = 0, an enabled trigger sets `done` on the next edge, and `valid_cnt` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start a new capture (pulse) |
| stop | input | 1 | End the running capture (pulse) |
| mode_sel | input | 2 | Position select, latched at arm: 0 mostly post, 1 center, 2 mostly pre, 3 continuous |
| smp_en | input | 1 | Sample enable |
| smp_data | input | DW | Sample word |
| trig | input | 1 | Trigger pulse from the upstream matcher |
| rd_idx | input | AW | Read index in time order, below DEPTH |
| rd_data | output | DW | Sample at `rd_idx`, one cycle later |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Window frozen and readable |
| valid_cnt | output | CW | Number of valid samples |
| trig_pos | output | CW | Time-order index of the trigger sample |

## Verification
If the write pointer or the held-sample count goes wrong, the readout sequence stops matching the input sequence. The error shows at the first index read after `done`: samples are missing, repeated or rotated. If the post-trigger counter goes wrong, `done` rises one or more samples early or late, and this is visible on the edge that should end the window. A write that continues after completion changes `valid_cnt` or `rd_data` on the next enabled sample.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        POS_POST = 2'd0,
        POS_MID  = 2'd1,
        POS_PRE  = 2'd2,
        POS_CONT = 2'd3
    } cap_pos_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_POST = 2'd2,
        ST_DONE = 2'd3
    } cap_st_e;

    // samples kept ahead of the trigger for a given position select
    function automatic int pre_share(input cap_pos_e m, input int depth);
        case (m)
            POS_POST: return depth / 8;
            POS_MID:  return depth / 2;
            POS_PRE:  return depth - depth / 8;
            default:  return depth;
        endcase
    endfunction

    function automatic int addr_w(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    function automatic int cnt_w(input int depth);
        return (depth > 0) ? $clog2(depth + 1) : 1;
    endfunction

endpackage

// File: rtl/cap_store.sv
module cap_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    generate
        if (DEPTH == 0) begin : g_none
            logic unused_in;
            assign unused_in = ^{wr_en, wr_addr, wr_data, rd_addr, rst};
            always_ff @(posedge clk) rd_data <= '0;
        end else begin : g_ram
            logic [DW-1:0] mem [DEPTH];
            always_ff @(posedge clk) begin
                if (wr_en) mem[wr_addr] <= wr_data;
                rd_data <= mem[rd_addr];
            end

            // R7
            wr_addr_range_chk: assert property (@(posedge clk) disable iff (rst)
                wr_en |-> (int'(wr_addr) < DEPTH));
        end
    endgenerate
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          stop,
    input  cap_pos_e      mode_sel,
    input  logic          smp_en,
    input  logic          trig,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] base_addr,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] valid_cnt,
    output logic [CW-1:0] trig_pos
);
    localparam int LAST = (DEPTH > 0) ? DEPTH - 1 : 0;

    cap_st_e       st;
    cap_pos_e      mode_q;
    logic [AW-1:0] wptr, wptr_nx;
    logic [CW-1:0] held, held_inc, kept, post_left;
    logic [CW-1:0] pre_lim, post_lim, k;
    logic          trig_eff;

    always_comb begin
        pre_lim  = CW'(pre_share(mode_q, DEPTH));
        post_lim = CW'(DEPTH) - pre_lim;
        wptr_nx  = (wptr == AW'(LAST)) ? '0 : wptr + 1'b1;
        held_inc = (held == CW'(DEPTH)) ? held : held + 1'b1;
        k        = (held < pre_lim) ? held : pre_lim;
        trig_eff = (st == ST_PRE) && smp_en && trig && (mode_q != POS_CONT);
        wr_en    = (DEPTH > 0) && smp_en &&
                   ((st == ST_POST) ||
                    ((st == ST_PRE) && !(trig_eff && post_lim == '0)));
    end

    // oldest valid sample sits held slots behind the write pointer
    always_comb begin
        int diff;
        diff = int'(wptr) - int'(held);
        if (diff < 0) diff = diff + DEPTH;
        base_addr = (DEPTH > 0) ? AW'(diff) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            mode_q    <= POS_POST;
            wptr      <= '0;
            held      <= '0;
            kept      <= '0;
            post_left <= '0;
        end else if (arm) begin
            st        <= ST_PRE;
            mode_q    <= mode_sel;
            wptr      <= '0;
            held      <= '0;
            kept      <= '0;
            post_left <= '0;
        end else if (stop && (st == ST_PRE || st == ST_POST)) begin
            st <= ST_DONE;
            if (st == ST_PRE) kept <= held;
        end else begin
            case (st)
                ST_PRE: begin
                    if (trig_eff) begin
                        kept <= k;
                        if (post_lim == '0) begin
                            held <= k;
                            st   <= ST_DONE;
                        end else begin
                            wptr <= wptr_nx;
                            held <= k + 1'b1;
                            if (post_lim == CW'(1)) begin
                                st <= ST_DONE;
                            end else begin
                                st        <= ST_POST;
                                post_left <= post_lim - 1'b1;
                            end
                        end
                    end else if (smp_en) begin
                        wptr <= wptr_nx;
                        held <= held_inc;
                    end
                end
                ST_POST: begin
                    if (smp_en) begin
                        wptr      <= wptr_nx;
                        held      <= held + 1'b1;
                        post_left <= post_left - 1'b1;
                        if (post_left == CW'(1)) st <= ST_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign wr_addr   = wptr;
    assign busy      = (st == ST_PRE) || (st == ST_POST);
    assign done      = (st == ST_DONE);
    assign valid_cnt = held;
    assign trig_pos  = kept;

    // R8
    done_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> (done && $stable(held) && $stable(wptr)));
    // R11
    arm_restart_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> (busy && !done && valid_cnt == '0));
    // R7
    idle_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !smp_en && !stop && !arm) |=> ($stable(held) && $stable(wptr)));
    // R6
    cont_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mode_q == POS_CONT && !stop && !arm) |=> busy);
    // R2
    held_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(valid_cnt) <= DEPTH) && (trig_pos <= valid_cnt || busy));
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
    import cap_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int AW    = addr_w(DEPTH),
    parameter int CW    = cnt_w(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  logic          stop,
    input  logic [1:0]    mode_sel,
    input  logic          smp_en,
    input  logic [DW-1:0] smp_data,
    input  logic          trig,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] valid_cnt,
    output logic [CW-1:0] trig_pos
);
    logic          wr_en;
    logic [AW-1:0] wr_addr, base_addr, rd_addr;

    cap_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .stop      (stop),
        .mode_sel  (cap_pos_e'(mode_sel)),
        .smp_en    (smp_en),
        .trig      (trig),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .base_addr (base_addr),
        .busy      (busy),
        .done      (done),
        .valid_cnt (valid_cnt),
        .trig_pos  (trig_pos)
    );

    // time-order index to physical slot, wrapping once modulo DEPTH
    always_comb begin
        int sum;
        sum = int'(base_addr) + int'(rd_idx);
        if (DEPTH > 0 && sum >= DEPTH) sum = sum - DEPTH;
        rd_addr = AW'(sum);
    end

    cap_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (smp_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/cap_buffer_bench.sv
`timescale 1ns/1ps
module cap_buffer_bench;
    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       arm = 1'b0, stop = 1'b0, smp_en = 1'b0, trig = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] smp_data = 8'd0;
    logic [3:0] rd_idx = 4'd0;
    logic [7:0] rd_data;
    logic       busy, done;
    logic [4:0] valid_cnt, trig_pos;
    logic [7:0] z_rd_data;
    logic       z_busy, z_done;
    logic       z_valid, z_tpos;

    int checks = 0, errors = 0;
    logic [7:0] sval = 8'd0;

    always #2 clk = ~clk;

    cap_buffer #(.DEPTH(D), .DW(8)) u_cap_buffer (
        .clk(clk), .rst(rst), .arm(arm), .stop(stop), .mode_sel(mode_sel),
        .smp_en(smp_en), .smp_data(smp_data), .trig(trig), .rd_idx(rd_idx),
        .rd_data(rd_data), .busy(busy), .done(done),
        .valid_cnt(valid_cnt), .trig_pos(trig_pos)
    );

    cap_buffer #(.DEPTH(0), .DW(8)) u_cap_zero (
        .clk(clk), .rst(rst), .arm(arm), .stop(stop), .mode_sel(mode_sel),
        .smp_en(smp_en), .smp_data(smp_data), .trig(trig), .rd_idx(1'b0),
        .rd_data(z_rd_data), .busy(z_busy), .done(z_done),
        .valid_cnt(z_valid), .trig_pos(z_tpos)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] npre;
        logic [7:0] tp;
        logic [7:0] post;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{mode: 2'd0, npre: 8'd20, tp: 8'd2,  post: 8'd14},  // R2
        '{mode: 2'd1, npre: 8'd20, tp: 8'd8,  post: 8'd8},   // R3
        '{mode: 2'd2, npre: 8'd20, tp: 8'd14, post: 8'd2},   // R4
        '{mode: 2'd1, npre: 8'd3,  tp: 8'd3,  post: 8'd8},   // R5
        '{mode: 2'd2, npre: 8'd0,  tp: 8'd0,  post: 8'd2},   // R5
        '{mode: 2'd0, npre: 8'd1,  tp: 8'd1,  post: 8'd14}   // R5
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_arm(input logic [1:0] m);
        mode_sel = m; arm = 1'b1;
        tick();
        arm = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        tick();
        stop = 1'b0;
    endtask

    task automatic sample(input logic tr);
        smp_en = 1'b1; smp_data = sval; trig = tr;
        tick();
        sval = sval + 8'd1;
        smp_en = 1'b0; trig = 1'b0;
    endtask

    task automatic read_at(input int idx, output logic [7:0] d);
        rd_idx = 4'(idx);
        tick();
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, tval, first;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(valid_cnt == 0 && trig_pos == 0, "R1 counts", valid_cnt, 0);

        // R2 R3 R4 R5 R9: table walk
        foreach (VECS[vi]) begin
            do_arm(VECS[vi].mode);
            for (int i = 0; i < int'(VECS[vi].npre); i++) sample(1'b0);
            tval = sval;
            sample(1'b1);
            for (int k = 2; k <= int'(VECS[vi].post); k++) begin
                if (k == int'(VECS[vi].post)) chk(!done, "R2/R3/R4 early done", done, 0);
                sample(1'b0);
            end
            chk(done, "R2/R3/R4 done after post count", done, 1);
            chk(trig_pos == 5'(VECS[vi].tp), "R5 trig_pos", trig_pos, VECS[vi].tp);
            chk(valid_cnt == 5'(VECS[vi].tp + VECS[vi].post), "R5 valid_cnt",
                valid_cnt, VECS[vi].tp + VECS[vi].post);
            bad = 0;
            for (int i = 0; i < int'(VECS[vi].tp + VECS[vi].post); i++) begin
                read_at(i, d);
                if (d != 8'(tval - VECS[vi].tp + 8'(i))) bad++;
            end
            chk(bad == 0, "R9 readout order", bad, 0);
        end

        // R6 continuous: trigger ignored, stop freezes last DEPTH samples
        do_arm(2'd3);
        first = sval;
        for (int i = 0; i < 20; i++) sample(i[1]);
        chk(busy && !done, "R6 still recording", done, 0);
        do_stop();
        chk(done && valid_cnt == 5'(D), "R6 valid after stop", valid_cnt, D);
        chk(trig_pos == 5'(D), "R6 trig_pos", trig_pos, D);
        read_at(0, d);
        chk(d == 8'(first + 8'd4), "R6 oldest", d, 8'(first + 8'd4));
        read_at(15, d);
        chk(d == 8'(first + 8'd19), "R6 newest", d, 8'(first + 8'd19));

        // R7 R10: disabled cycles neither store nor trigger; stop before trigger
        do_arm(2'd1);
        first = sval;
        for (int i = 0; i < 3; i++) sample(1'b0);
        for (int i = 0; i < 4; i++) begin
            smp_en = 1'b0; trig = 1'b1; smp_data = 8'hEE;
            tick();
        end
        trig = 1'b0;
        chk(busy && !done, "R7 trigger without enable ignored", done, 0);
        do_stop();
        chk(done && valid_cnt == 5'd3, "R10 valid after stop", valid_cnt, 3);
        chk(trig_pos == 5'd3, "R10 trig_pos", trig_pos, 3);
        bad = 0;
        for (int i = 0; i < 3; i++) begin
            read_at(i, d);
            if (d != 8'(first + 8'(i))) bad++;
        end
        chk(bad == 0, "R7 only enabled samples stored", bad, 0);

        // R8 frozen after done
        for (int i = 0; i < 5; i++) sample(1'b1);
        chk(done && valid_cnt == 5'd3, "R8 valid frozen", valid_cnt, 3);
        read_at(0, d);
        chk(d == first, "R8 data frozen", d, first);

        // R11 re-arm
        do_arm(2'd1);
        chk(busy && !done && valid_cnt == 0, "R11 re-arm", {busy, done}, 2);

        // R12 zero depth
        sample(1'b1);
        chk(z_done && !z_busy, "R12 zero depth done", z_done, 1);
        chk(z_valid == 1'b0, "R12 zero depth valid", z_valid, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule